// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver

This block receives asynchronous serial characters in which every character carries one extra marker bit after its data bits. A marker of 1 tags the character as a station address and a marker of 0 tags it as payload. The receiver samples an oversampled line, rebuilds each frame and hands the character to a host through a data register, a set of status flags and an interrupt line.

A host that is not being addressed sets the wait bit in the control register. While that bit is set, payload characters are thrown away: nothing reaches the data register and no status flag is raised. The first address character clears the wait bit by itself and is delivered like any other character. The host then compares the delivered address with its own and sets the wait bit again if the traffic is meant for another station.

Top module: `mpf_uart_rx`

## Requirements
- R1: A frame is an idle-high line, a start bit of 0, DATA_W data bits LSB first, one marker bit and one stop bit. No parity bit is ever sampled. Each bit lasts OVS pulses of tick_i, and each bit is sampled at its centre.
- R2: Outside wait mode, every completed frame loads its data bits into rdata_o and its marker into mpb_o and sets full_o, as long as full_o was clear or a read arrives in the same cycle.
- R3: While wait_o is 1, a character with marker 0 leaves rdata_o, mpb_o and full_o unchanged.
- R4: While wait_o is 1, a character with marker 0 sets neither ferr_o nor ovr_o, even when its stop bit is 0.
- R5: A character with marker 1 that arrives while wait_o is 1 clears wait_o, is loaded into rdata_o, sets mpb_o to 1 and sets full_o. The characters after it are received normally.
- R6: An accepted character whose stop bit is sampled as 0 sets ferr_o and is still loaded into rdata_o.
- R7: irq_o is 1 exactly when full_o and rie_o are both 1.
- R8: An accepted character that completes while full_o is 1, with no read in the same cycle, sets ovr_o and leaves rdata_o with its old value.
- R9: rd_i clears full_o and clr_err_i clears ferr_o and ovr_o. A completing character in the same cycle takes priority over either clear.
- R10: A pulse on ctrl_we_i loads ctrl_wait_i into wait_o and ctrl_rie_i into rie_o. This write takes priority over the automatic clear of wait_o.
- R11: After reset, wait_o, rie_o, full_o, ferr_o, ovr_o, mpb_o and irq_o are 0 and rdata_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, OVS pulses per bit |
| rx_i | input | 1 | Serial line, idle high |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wait_i | input | 1 | Wait-bit value to write |
| ctrl_rie_i | input | 1 | Interrupt-enable value to write |
| rd_i | input | 1 | Data register read strobe |
| clr_err_i | input | 1 | Error flag clear strobe |
| wait_o | output | 1 | Wait bit |
| rie_o | output | 1 | Receive interrupt enable |
| rdata_o | output | DATA_W | Receive data register |
| mpb_o | output | 1 | Marker bit of the last loaded character |
| full_o | output | 1 | Receive data register full |
| ferr_o | output | 1 | Framing error flag |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Receive interrupt |

## Verification
The test sends payload characters and address characters outside wait mode to show that the data bits and the marker are captured unchanged. Inside wait mode it sends a payload character with a good stop bit and another with a bad stop bit. These show that wait mode suppresses both delivery and error reporting, and that an address character alone ends it. It also sends a character with a bad stop bit outside wait mode, which separates a framing error from a discarded character. Two characters in a row with no read between them show that an overrun keeps the old data. A final character sent with the interrupt disabled shows that full_o alone does not raise irq_o.

// File: rtl/mpf_rx_pkg.sv
package mpf_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/mpf_rx_frame.sv
module mpf_rx_frame
   import mpf_rx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OVS      = 16,
   parameter int SYNC_STG = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              rx_i,
   output logic              frm_vld_o,
   output logic [DATA_W-1:0] frm_data_o,
   output logic              frm_mpb_o,
   output logic              frm_stop_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W + 2);
   localparam int HALF  = OVS / 2;

   logic [SYNC_STG-1:0] sync_q;
   logic                rx_s, rx_d;
   rx_state_e           state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [IDX_W-1:0]    idx_q;
   logic [DATA_W:0]     shreg_q;

   // synchronizer chain, one flop per stage
   for (genvar g = 0; g < SYNC_STG; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) sync_q[0] <= 1'b1;
            else         sync_q[0] <= rx_i;
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) sync_q[g] <= 1'b1;
            else         sync_q[g] <= sync_q[g-1];
      end
   end

   assign rx_s = sync_q[SYNC_STG-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= RX_IDLE;
         cnt_q      <= '0;
         idx_q      <= '0;
         shreg_q    <= '0;
         rx_d       <= 1'b1;
         frm_vld_o  <= 1'b0;
         frm_stop_o <= 1'b1;
      end else begin
         frm_vld_o <= 1'b0;
         if (tick_i) begin
            rx_d <= rx_s;
            unique case (state_q)
               RX_IDLE: begin
                  if (rx_d && !rx_s) begin
                     state_q <= RX_START;
                     cnt_q   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == CNT_W'(HALF - 1)) begin
                     state_q <= rx_s ? RX_IDLE : RX_BITS;
                     cnt_q   <= '0;
                     idx_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (cnt_q == CNT_W'(OVS - 1)) begin
                     cnt_q   <= '0;
                     shreg_q <= {rx_s, shreg_q[DATA_W:1]};
                     if (idx_q == IDX_W'(DATA_W)) state_q <= RX_STOP;
                     else                         idx_q   <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == CNT_W'(OVS - 1)) begin
                     cnt_q      <= '0;
                     frm_vld_o  <= 1'b1;
                     frm_stop_o <= rx_s;
                     state_q    <= RX_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign frm_data_o = shreg_q[DATA_W-1:0];
   assign frm_mpb_o  = shreg_q[DATA_W];
endmodule

// File: rtl/mpf_rx_status.sv
module mpf_rx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frm_vld_i,
   input  logic [DATA_W-1:0] frm_data_i,
   input  logic              frm_mpb_i,
   input  logic              frm_stop_i,
   input  logic              ctrl_we_i,
   input  logic              ctrl_wait_i,
   input  logic              ctrl_rie_i,
   input  logic              rd_i,
   input  logic              clr_err_i,
   output logic              wait_o,
   output logic              rie_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              mpb_o,
   output logic              full_o,
   output logic              ferr_o,
   output logic              ovr_o,
   output logic              irq_o
);
   logic skip, take, load, overrun;

   assign skip    = wait_o && !frm_mpb_i;
   assign take    = frm_vld_i && !skip;
   assign load    = take && (!full_o || rd_i);
   assign overrun = take && full_o && !rd_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wait_o  <= 1'b0;
         rie_o   <= 1'b0;
         rdata_o <= '0;
         mpb_o   <= 1'b0;
         full_o  <= 1'b0;
         ferr_o  <= 1'b0;
         ovr_o   <= 1'b0;
      end else begin
         if (ctrl_we_i) begin
            wait_o <= ctrl_wait_i;
            rie_o  <= ctrl_rie_i;
         end else if (frm_vld_i && frm_mpb_i) begin
            wait_o <= 1'b0;
         end

         if (load) begin
            rdata_o <= frm_data_i;
            mpb_o   <= frm_mpb_i;
         end

         if (take)      full_o <= 1'b1;
         else if (rd_i) full_o <= 1'b0;

         if (take && !frm_stop_i) ferr_o <= 1'b1;
         else if (clr_err_i)      ferr_o <= 1'b0;

         if (overrun)        ovr_o <= 1'b1;
         else if (clr_err_i) ovr_o <= 1'b0;
      end
   end

   assign irq_o = full_o && rie_o;
endmodule

// File: rtl/mpf_uart_rx.sv
module mpf_uart_rx #(
   parameter int DATA_W   = 8,
   parameter int OVS      = 16,
   parameter int SYNC_STG = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic              ctrl_we_i,
   input  logic              ctrl_wait_i,
   input  logic              ctrl_rie_i,
   input  logic              rd_i,
   input  logic              clr_err_i,
   output logic              wait_o,
   output logic              rie_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              mpb_o,
   output logic              full_o,
   output logic              ferr_o,
   output logic              ovr_o,
   output logic              irq_o
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("mpf_uart_rx: DATA_W must lie in 5..9");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("mpf_uart_rx: OVS must be even and at least 4");
   end
   if (SYNC_STG < 2) begin : g_bad_sync
      $error("mpf_uart_rx: SYNC_STG must be at least 2");
   end

   logic              frm_vld;
   logic [DATA_W-1:0] frm_data;
   logic              frm_mpb;
   logic              frm_stop;

   mpf_rx_frame #(
      .DATA_W  (DATA_W),
      .OVS     (OVS),
      .SYNC_STG(SYNC_STG)
   ) u_frame (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .rx_i      (rx_i),
      .frm_vld_o (frm_vld),
      .frm_data_o(frm_data),
      .frm_mpb_o (frm_mpb),
      .frm_stop_o(frm_stop)
   );

   mpf_rx_status #(
      .DATA_W(DATA_W)
   ) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frm_vld_i  (frm_vld),
      .frm_data_i (frm_data),
      .frm_mpb_i  (frm_mpb),
      .frm_stop_i (frm_stop),
      .ctrl_we_i  (ctrl_we_i),
      .ctrl_wait_i(ctrl_wait_i),
      .ctrl_rie_i (ctrl_rie_i),
      .rd_i       (rd_i),
      .clr_err_i  (clr_err_i),
      .wait_o     (wait_o),
      .rie_o      (rie_o),
      .rdata_o    (rdata_o),
      .mpb_o      (mpb_o),
      .full_o     (full_o),
      .ferr_o     (ferr_o),
      .ovr_o      (ovr_o),
      .irq_o      (irq_o)
   );
endmodule

// File: rtl/mpf_uart_rx_chk.sv
module mpf_uart_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              frm_vld,
   input logic              frm_mpb,
   input logic              ctrl_we_i,
   input logic              rd_i,
   input logic              wait_o,
   input logic              rie_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic              mpb_o,
   input logic              full_o,
   input logic              ferr_o,
   input logic              ovr_o,
   input logic              irq_o
);
   AST_SKIP_NO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wait_o && frm_vld && !frm_mpb && !full_o) |=> !full_o); // R3
   AST_SKIP_KEEP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wait_o && frm_vld && !frm_mpb) |=> ($stable(rdata_o) && $stable(mpb_o))); // R3
   AST_SKIP_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wait_o && frm_vld && !frm_mpb && !ferr_o && !ovr_o) |=> (!ferr_o && !ovr_o)); // R4
   AST_ID_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wait_o && frm_vld && frm_mpb && !ctrl_we_i) |=> !wait_o); // R5
   AST_ID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld && frm_mpb && !full_o) |=> (full_o && mpb_o)); // R5
   AST_IRQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld && rie_o && !ctrl_we_i && !(wait_o && !frm_mpb)) |=> irq_o); // R7
   AST_OVR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld && full_o && !rd_i && !(wait_o && !frm_mpb)) |=> (ovr_o && $stable(rdata_o))); // R8
   AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !frm_vld) |=> !full_o); // R9
endmodule

bind mpf_uart_rx mpf_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .frm_vld  (frm_vld),
   .frm_mpb  (frm_mpb),
   .ctrl_we_i(ctrl_we_i),
   .rd_i     (rd_i),
   .wait_o   (wait_o),
   .rie_o    (rie_o),
   .rdata_o  (rdata_o),
   .mpb_o    (mpb_o),
   .full_o   (full_o),
   .ferr_o   (ferr_o),
   .ovr_o    (ovr_o),
   .irq_o    (irq_o)
);

// File: tb/mpf_uart_rx_bench.sv
`timescale 1ns/1ps
module mpf_uart_rx_bench;
   localparam int DW      = 8;
   localparam int OVS     = 16;
   localparam int BIT_CYC = OVS * 2;

   typedef struct packed {
      logic [DW-1:0] d;
      logic          m;
      logic          fe;
      logic          irq;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
   logic ctrl_we = 1'b0, ctrl_wait = 1'b0, ctrl_rie = 1'b0;
   logic man_rd = 1'b0, mon_rd = 1'b0, clr_err = 1'b0;
   logic wait_o, rie_o, mpb_o, full_o, ferr_o, ovr_o, irq_o;
   logic [DW-1:0] rdata_o;

   int   checks = 0, errors = 0;
   bit   auto_rd = 1'b1, rie_m = 1'b0, full_seen = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) tick <= ~tick;

   mpf_uart_rx #(.DATA_W(DW), .OVS(OVS), .SYNC_STG(2)) u_mpf_uart_rx (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx),
      .ctrl_we_i(ctrl_we), .ctrl_wait_i(ctrl_wait), .ctrl_rie_i(ctrl_rie),
      .rd_i(man_rd | mon_rd), .clr_err_i(clr_err),
      .wait_o(wait_o), .rie_o(rie_o), .rdata_o(rdata_o), .mpb_o(mpb_o),
      .full_o(full_o), .ferr_o(ferr_o), .ovr_o(ovr_o), .irq_o(irq_o));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: pushes the expected item, then shifts the frame onto the line
   task automatic send(input logic [DW-1:0] d, input logic m, input logic st,
                       input bit push, input bit fe);
      if (push) q.push_back('{d: d, m: m, fe: fe, irq: rie_m});
      @(negedge clk) rx = 1'b0;
      repeat (BIT_CYC) @(negedge clk);
      for (int i = 0; i < DW; i++) begin
         rx = d[i];
         repeat (BIT_CYC) @(negedge clk);
      end
      rx = m;
      repeat (BIT_CYC) @(negedge clk);
      rx = st;
      repeat (BIT_CYC) @(negedge clk);
      rx = 1'b1;
      repeat (2 * BIT_CYC) @(negedge clk);
   endtask

   task automatic ctrl_write(input logic w, input logic r);
      @(negedge clk) begin ctrl_we = 1'b1; ctrl_wait = w; ctrl_rie = r; end
      @(negedge clk) ctrl_we = 1'b0;
      rie_m = r;
   endtask

   task automatic pulse_clr();
      @(negedge clk) clr_err = 1'b1;
      @(negedge clk) clr_err = 1'b0;
   endtask

   // monitor: pops an expected item on every rising edge of full_o
   initial begin
      forever begin
         @(negedge clk);
         if (!full_o) full_seen = 1'b0;
         else if (!full_seen) begin
            full_seen = 1'b1;
            if (q.size() == 0) begin
               chk(1'b0, "R2 unexpected load", 32'(rdata_o), 32'hx);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(rdata_o == e.d, "R2 data", 32'(rdata_o), 32'(e.d));
               chk(mpb_o == e.m, "R2 marker", 32'(mpb_o), 32'(e.m));
               chk(ferr_o == e.fe, "R6 framing flag", 32'(ferr_o), 32'(e.fe));
               chk(irq_o == e.irq, "R7 interrupt", 32'(irq_o), 32'(e.irq));
            end
            if (auto_rd) begin
               mon_rd = 1'b1;
               @(negedge clk) mon_rd = 1'b0;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R11 reset state
      chk({wait_o, rie_o, full_o, ferr_o, ovr_o, mpb_o, irq_o} == 7'b0, "R11 flags",
          32'({wait_o, rie_o, full_o, ferr_o, ovr_o, mpb_o, irq_o}), 32'd0);
      chk(rdata_o == '0, "R11 data", 32'(rdata_o), 32'd0);
      rst_n = 1'b1;
      repeat (4 * BIT_CYC) @(negedge clk);

      // R1 framing and R2 normal load, payload and address characters
      send(8'hA5, 1'b0, 1'b1, 1'b1, 1'b0);
      send(8'h3C, 1'b0, 1'b1, 1'b1, 1'b0);
      send(8'h12, 1'b1, 1'b1, 1'b1, 1'b0);
      chk(mpb_o == 1'b1, "R2 marker kept", 32'(mpb_o), 32'd1);
      chk(wait_o == 1'b0, "R2 no wait", 32'(wait_o), 32'd0);

      // R10 control write
      ctrl_write(1'b1, 1'b1);
      chk(wait_o == 1'b1, "R10 wait set", 32'(wait_o), 32'd1);
      chk(rie_o == 1'b1, "R10 rie set", 32'(rie_o), 32'd1);

      // R3 payload skipped in wait mode
      send(8'h55, 1'b0, 1'b1, 1'b0, 1'b0);
      chk(full_o == 1'b0, "R3 full", 32'(full_o), 32'd0);
      chk(rdata_o == 8'h12, "R3 data", 32'(rdata_o), 32'h12);
      chk(wait_o == 1'b1, "R3 wait held", 32'(wait_o), 32'd1);

      // R4 bad stop bit in wait mode raises no error
      send(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
      chk(ferr_o == 1'b0, "R4 ferr", 32'(ferr_o), 32'd0);
      chk(ovr_o == 1'b0, "R4 ovr", 32'(ovr_o), 32'd0);
      chk(full_o == 1'b0, "R4 full", 32'(full_o), 32'd0);

      // R5 address ends wait mode and is delivered
      send(8'h42, 1'b1, 1'b1, 1'b1, 1'b0);
      chk(wait_o == 1'b0, "R5 wait cleared", 32'(wait_o), 32'd0);
      chk(mpb_o == 1'b1, "R5 marker", 32'(mpb_o), 32'd1);
      send(8'h99, 1'b0, 1'b1, 1'b1, 1'b0);
      chk(mpb_o == 1'b0, "R5 resumed", 32'(mpb_o), 32'd0);

      // R6 framing error outside wait mode
      send(8'h0F, 1'b0, 1'b0, 1'b1, 1'b1);
      chk(ferr_o == 1'b1, "R6 ferr set", 32'(ferr_o), 32'd1);
      pulse_clr();
      chk(ferr_o == 1'b0, "R9 ferr cleared", 32'(ferr_o), 32'd0);

      // R8 overrun keeps old data
      auto_rd = 1'b0;
      send(8'h11, 1'b0, 1'b1, 1'b1, 1'b0);
      send(8'h22, 1'b0, 1'b1, 1'b0, 1'b0);
      chk(ovr_o == 1'b1, "R8 ovr set", 32'(ovr_o), 32'd1);
      chk(rdata_o == 8'h11, "R8 data kept", 32'(rdata_o), 32'h11);
      chk(full_o == 1'b1, "R8 full", 32'(full_o), 32'd1);
      @(negedge clk) man_rd = 1'b1;
      @(negedge clk) man_rd = 1'b0;
      chk(full_o == 1'b0, "R9 read clears full", 32'(full_o), 32'd0);
      pulse_clr();
      chk(ovr_o == 1'b0, "R9 ovr cleared", 32'(ovr_o), 32'd0);
      auto_rd = 1'b1;

      // R7 no interrupt when disabled
      ctrl_write(1'b0, 1'b0);
      send(8'hC3, 1'b0, 1'b1, 1'b1, 1'b0);
      chk(irq_o == 1'b0, "R7 irq low", 32'(irq_o), 32'd0);

      chk(q.size() == 0, "R2 all items seen", 32'(q.size()), 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule